// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the part of an 8-bit processor core that moves the program counter to a vector and manages the hardware stack. After reset it reads a two-byte start address from memory. After that it waits for either a stack request from the core or a non-maskable interrupt. Interrupt entry saves the return address and the flag byte on the stack, sets the interrupt-disable flag, and fetches the handler address. All of this uses a byte-wide memory bus with an asynchronous read.

The core keeps the program counter and presents it on `pc_in`. The core stalls while `busy` is high. When `pc_load` pulses, the core takes the new address from `pc_vec`. The stack pointer and the flag byte are held in this block. The core can push, pop and write the flag byte only while the block is not busy.

States: `S_RST_LO` (fetch low start byte) → `S_RST_HI` (fetch high start byte, load PC) → `S_IDLE`. From `S_IDLE`, a pending interrupt takes the entry transition `S_PUSH_PCH` → `S_PUSH_PCL` → `S_PUSH_STAT` → `S_VEC_LO` → `S_VEC_HI` → back to `S_IDLE`. Every other transition is unconditional. In `S_IDLE` with nothing pending, the block serves core stack requests and flag writes, and stays in `S_IDLE`.

Top module: `int_entry_seq`

## Requirements
- R1: While reset is held and in the first cycle after its release, `sp_out` is 0xFF, `status_out` is 0x20 and `busy` is 1. The first bus cycle reads 0xFFFC. The next bus cycle reads 0xFFFD, pulses `pc_load` and shows `pc_vec` = {byte at 0xFFFD, byte at 0xFFFC}. After that `busy` falls.
- R2: An accepted core push drives `mem_we`=1, `mem_addr`=0x0100 | SP and `mem_wdata`=`core_wdata`, and SP then decreases by one modulo 256 (0x00 becomes 0xFF). Every stack write goes to page 0x01.
- R3: An accepted core pop first increases SP by one modulo 256 and reads at 0x0100 | new SP with `mem_we`=0 (SP 0xFF reads 0x0100 and becomes 0x00).
- R4: An interrupt is latched only in a cycle where `nmi_req` is 1, `nmi_req` was 0 in the cycle before, and `nmi_gate` is 1. An edge with the gate at 0 is dropped. A level held high never latches again, even after the gate rises.
- R5: Entry writes the high PC byte, then the low PC byte, then the flag byte, on three consecutive cycles. These go to 0x0100 | SP, 0x0100 | (SP−1) and 0x0100 | (SP−2), and SP ends 3 lower.
- R6: The pushed flag byte is the value before entry. From the cycle after that push, `status_out` bit 2 (interrupt disable) is 1 and the other bits are unchanged.
- R7: After the pushes, the block reads 0xFFFA and then 0xFFFB. In the 0xFFFB cycle it pulses `pc_load` with `pc_vec` = {byte at 0xFFFB, byte at 0xFFFA}.
- R8: `busy` is 1 from the cycle after an interrupt is latched until the `pc_load` cycle. While it is 1, the block ignores `core_push`, `core_pop` and `stat_we`.
- R9: If `core_push` and `core_pop` are both 1 in an accepted cycle, only the push is performed.
- R10: The pending interrupt clears when entry begins. A new qualifying edge during entry produces exactly one further entry, which starts right after the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable interrupt request line |
| nmi_gate | input | 1 | Enable bit from the external video control register |
| pc_in | input | 16 | Current program counter from the core |
| core_push | input | 1 | Core stack push request |
| core_pop | input | 1 | Core stack pop request |
| core_wdata | input | 8 | Byte to push |
| stat_we | input | 1 | Core write of the flag byte |
| stat_wdata | input | 8 | New flag byte value |
| mem_rdata | input | 8 | Read data from memory (same-cycle) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| sp_out | output | 8 | Stack pointer |
| status_out | output | 8 | Flag byte |
| pc_vec | output | 16 | Vector address for the core's program counter |
| pc_load | output | 1 | Load strobe for `pc_vec` |
| busy | output | 1 | Sequence in progress; core must stall |

## Verification
An interrupt edge can arrive in the same cycle that the core issues a push, a pop or a flag write. The block may then not be able to tell whether the pending entry or the core request owns the bus. The bench provokes this overlap by driving core requests in the cycle after the edge and during the first push. It judges the outcome at the ports:
- no extra write may appear;
- the stack pointer must end exactly three lower;
- the flag byte must show only the interrupt-disable bit added.

A second edge during an entry is used to check that exactly one further entry follows.

// File: rtl/ies_pkg.sv
package ies_pkg;

    typedef enum logic [2:0] {
        S_RST_LO,
        S_RST_HI,
        S_IDLE,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_STAT,
        S_VEC_LO,
        S_VEC_HI
    } ies_state_e;

    localparam logic [15:0] IES_VEC_MASKABLE = 16'hFFFE;

    function automatic logic [15:0] ies_vec_hi(input logic [15:0] lo_addr);
        return lo_addr | 16'h0001;
    endfunction

endpackage

// File: rtl/ies_nmi_latch.sv
module ies_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic gate_i,
    input  logic take_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    // a line that is already high when reset ends is not an edge
    assign rise   = req_i & ~prev_q & gate_i;
    assign pend_o = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= req_i;
            // a fresh edge wins over the clear
            pend_q <= rise | (pend_q & ~take_i);
        end
    end
endmodule

// File: rtl/ies_stack_ptr.sv
module ies_stack_ptr #(
    parameter int             DW      = 8,
    parameter logic [DW-1:0]  SP_INIT = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_i,
    input  logic          inc_i,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] sp_up_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] sp_q;

    assign sp_o    = sp_q;
    assign sp_up_o = sp_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= SP_INIT;
        end else if (dec_i) begin
            sp_q <= sp_q - ONE;
        end else if (inc_i) begin
            sp_q <= sp_up_o;
        end
    end
endmodule

// File: rtl/ies_status_reg.sv
module ies_status_reg #(
    parameter int            DW       = 8,
    parameter logic [DW-1:0] INIT     = 8'h20,
    parameter int            IDIS_BIT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wd_i,
    input  logic          set_idis_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] q;

    assign q_o = q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (set_idis_i) begin
            q[IDIS_BIT] <= 1'b1;
        end else if (wr_i) begin
            q <= wd_i;
        end
    end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
    import ies_pkg::*;
#(
    parameter int                AW          = 16,
    parameter int                DW          = 8,
    parameter logic [AW-DW-1:0]  STACK_PAGE  = 8'h01,
    parameter logic [DW-1:0]     SP_INIT     = 8'hFF,
    parameter logic [DW-1:0]     STATUS_INIT = 8'h20,
    parameter int                IDIS_BIT    = 2,
    parameter logic [AW-1:0]     NMI_VEC     = 16'hFFFA,
    parameter logic [AW-1:0]     RST_VEC     = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          nmi_gate,
    input  logic [AW-1:0] pc_in,
    input  logic          core_push,
    input  logic          core_pop,
    input  logic [DW-1:0] core_wdata,
    input  logic          stat_we,
    input  logic [DW-1:0] stat_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] status_out,
    output logic [AW-1:0] pc_vec,
    output logic          pc_load,
    output logic          busy
);
    localparam logic [AW-1:0] NMI_VEC_HI = NMI_VEC | AW'(1);
    localparam logic [AW-1:0] RST_VEC_HI = RST_VEC | AW'(1);

    ies_state_e    state_q, state_d;
    logic          pend;
    logic          take;
    logic          sp_dec, sp_inc;
    logic [DW-1:0] sp, sp_up;
    logic          st_wr, st_set;
    logic          lo_cap;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] status_q;

    ies_nmi_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (nmi_req),
        .gate_i (nmi_gate),
        .take_i (take),
        .pend_o (pend)
    );

    ies_stack_ptr #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec_i   (sp_dec),
        .inc_i   (sp_inc),
        .sp_o    (sp),
        .sp_up_o (sp_up)
    );

    ies_status_reg #(.DW(DW), .INIT(STATUS_INIT), .IDIS_BIT(IDIS_BIT)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (st_wr),
        .wd_i       (stat_wdata),
        .set_idis_i (st_set),
        .q_o        (status_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RST_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // captured low vector byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (lo_cap) begin
            lo_q <= mem_rdata;
        end
    end

    // outputs and next state
    always_comb begin
        state_d   = state_q;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        take      = 1'b0;
        st_wr     = 1'b0;
        st_set    = 1'b0;
        lo_cap    = 1'b0;
        pc_load   = 1'b0;
        unique case (state_q)
            S_RST_LO: begin
                mem_addr = RST_VEC;
                lo_cap   = 1'b1;
                state_d  = S_RST_HI;
            end
            S_RST_HI: begin
                mem_addr = RST_VEC_HI;
                pc_load  = 1'b1;
                state_d  = S_IDLE;
            end
            S_IDLE: begin
                if (pend) begin
                    take    = 1'b1;
                    state_d = S_PUSH_PCH;
                end else begin
                    st_wr = stat_we;
                    if (core_push) begin
                        mem_we    = 1'b1;
                        mem_addr  = {STACK_PAGE, sp};
                        mem_wdata = core_wdata;
                        sp_dec    = 1'b1;
                    end else if (core_pop) begin
                        mem_addr = {STACK_PAGE, sp_up};
                        sp_inc   = 1'b1;
                    end
                end
            end
            S_PUSH_PCH: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = pc_in[AW-1:AW-DW];
                sp_dec    = 1'b1;
                state_d   = S_PUSH_PCL;
            end
            S_PUSH_PCL: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = pc_in[DW-1:0];
                sp_dec    = 1'b1;
                state_d   = S_PUSH_STAT;
            end
            S_PUSH_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = {STACK_PAGE, sp};
                mem_wdata = status_q;
                sp_dec    = 1'b1;
                st_set    = 1'b1;
                state_d   = S_VEC_LO;
            end
            S_VEC_LO: begin
                mem_addr = NMI_VEC;
                lo_cap   = 1'b1;
                state_d  = S_VEC_HI;
            end
            S_VEC_HI: begin
                mem_addr = NMI_VEC_HI;
                pc_load  = 1'b1;
                state_d  = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign pc_vec     = {mem_rdata, lo_q};
    assign sp_out     = sp;
    assign status_out = status_q;
    assign busy       = (state_q != S_IDLE) | pend;

endmodule

// File: rtl/int_entry_seq_chk.sv
module int_entry_seq_chk #(
    parameter int               AW         = 16,
    parameter int               DW         = 8,
    parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01,
    parameter int               IDIS_BIT   = 2,
    parameter logic [AW-1:0]    NMI_VEC    = 16'hFFFA
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_push,
    input logic          core_pop,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] sp_out,
    input logic [DW-1:0] status_out,
    input logic          pc_load,
    input logic          busy
);
    localparam logic [DW-1:0] ONE = DW'(1);

    // R1: reset leaves the stack pointer at its top
    p_sp_reset_r1: assert property (@(posedge clk)
        !rst_n |=> sp_out == {DW{1'b1}});

    // R2: every write lands in the stack page at the current pointer
    p_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == {STACK_PAGE, sp_out});

    // R2: each write is followed by a one-step decrement
    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_out == $past(sp_out) - ONE);

    // R3: a lone accepted pop increments
    p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && core_pop && !core_push) |=> sp_out == $past(sp_out) + ONE);

    // R6: the interrupt-disable flag is set by the time the handler address loads
    p_idis_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && mem_addr == (NMI_VEC | AW'(1))) |-> status_out[IDIS_BIT]);

    // R7: the load strobe only accompanies the high byte of a vector
    p_vec_odd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (mem_addr[0] && !mem_we));

    // R8: busy cycles without writes leave the pointer untouched
    p_sp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> $stable(sp_out));

endmodule

bind int_entry_seq int_entry_seq_chk #(
    .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE), .IDIS_BIT(IDIS_BIT), .NMI_VEC(NMI_VEC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_push  (core_push),
    .core_pop   (core_pop),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .sp_out     (sp_out),
    .status_out (status_out),
    .pc_load    (pc_load),
    .busy       (busy)
);

// File: tb/int_entry_seq_tb_top.sv
module int_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_req, nmi_gate;
    logic [15:0] pc_in;
    logic        core_push, core_pop, stat_we;
    logic [7:0]  core_wdata, stat_wdata, mem_rdata;
    logic [15:0] mem_addr, pc_vec;
    logic [7:0]  mem_wdata, sp_out, status_out;
    logic        mem_we, pc_load, busy;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [7:0] sp_exp, st_exp;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    int_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .nmi_gate(nmi_gate),
        .pc_in(pc_in), .core_push(core_push), .core_pop(core_pop),
        .core_wdata(core_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .sp_out(sp_out), .status_out(status_out),
        .pc_vec(pc_vec), .pc_load(pc_load), .busy(busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        core_push = 1'b0;
        core_pop  = 1'b0;
        stat_we   = 1'b0;
    endtask

    task automatic chk_regs(input string req);
        chk(req, "sp_out", 32'(sp_out), 32'(sp_exp));
        chk(req, "status_out", 32'(status_out), 32'(st_exp));
    endtask

    task automatic do_push(input logic [7:0] d, input bit with_pop);
        next_cycle();
        core_push  = 1'b1;
        core_pop   = with_pop;
        core_wdata = d;
        #1;
        chk_regs("R2");
        chk(with_pop ? "R9" : "R2", "push we", 32'(mem_we), 32'd1);
        chk(with_pop ? "R9" : "R2", "push addr", 32'(mem_addr), 32'({8'h01, sp_exp}));
        chk("R2", "push data", 32'(mem_wdata), 32'(d));
        sp_exp = sp_exp - 8'd1;
    endtask

    task automatic do_pop();
        next_cycle();
        core_pop = 1'b1;
        #1;
        chk_regs("R3");
        chk("R3", "pop we", 32'(mem_we), 32'd0);
        chk("R3", "pop addr", 32'(mem_addr), 32'({8'h01, 8'(sp_exp + 8'd1)}));
        sp_exp = sp_exp + 8'd1;
    endtask

    task automatic do_stat(input logic [7:0] d);
        next_cycle();
        stat_we    = 1'b1;
        stat_wdata = d;
        #1;
        chk_regs("R8");
        st_exp = d;
    endtask

    // starts in the cycle where the pending request is visible
    task automatic run_entry(input bit inject, input bit retrig);
        logic [7:0] st_pushed;
        next_cycle();
        if (inject) begin
            core_push = 1'b1; core_wdata = 8'hA5;
            stat_we = 1'b1; stat_wdata = 8'h00;
        end
        #1;
        chk("R8", "busy pending", 32'(busy), 32'd1);
        chk("R8", "no write pending", 32'(mem_we), 32'd0);
        next_cycle();
        if (inject) core_pop = 1'b1;
        if (retrig) nmi_req = 1'b0;
        #1;
        chk("R5", "pch we", 32'(mem_we), 32'd1);
        chk("R5", "pch addr", 32'(mem_addr), 32'({8'h01, sp_exp}));
        chk("R5", "pch data", 32'(mem_wdata), 32'(pc_in[15:8]));
        next_cycle();
        if (retrig) begin nmi_req = 1'b1; nmi_gate = 1'b1; end
        #1;
        chk("R5", "pcl addr", 32'(mem_addr), 32'({8'h01, 8'(sp_exp - 8'd1)}));
        chk("R5", "pcl data", 32'(mem_wdata), 32'(pc_in[7:0]));
        next_cycle();
        #1;
        st_pushed = st_exp;
        chk("R5", "stat addr", 32'(mem_addr), 32'({8'h01, 8'(sp_exp - 8'd2)}));
        chk("R6", "pushed status", 32'(mem_wdata), 32'(st_pushed));
        st_exp = st_exp | 8'h04;
        sp_exp = sp_exp - 8'd3;
        next_cycle();
        #1;
        chk("R7", "vec lo addr", 32'(mem_addr), 32'h0000FFFA);
        chk("R7", "vec lo we", 32'(mem_we), 32'd0);
        chk("R6", "status after", 32'(status_out), 32'(st_exp));
        chk("R5", "sp after", 32'(sp_out), 32'(sp_exp));
        next_cycle();
        #1;
        chk("R7", "vec hi addr", 32'(mem_addr), 32'h0000FFFB);
        chk("R7", "pc_load", 32'(pc_load), 32'd1);
        chk("R7", "pc_vec", 32'(pc_vec), 32'({mem_fn(16'hFFFB), mem_fn(16'hFFFA)}));
    endtask

    task automatic do_nmi(input bit gate, input bit inject);
        pc_in = 16'($urandom);
        next_cycle();
        nmi_req  = 1'b1;
        nmi_gate = gate;
        #1;
        chk("R4", "busy at edge", 32'(busy), 32'd0);
        if (!gate) begin
            next_cycle();
            nmi_gate = 1'b1;
            #1;
            chk("R4", "gated edge busy", 32'(busy), 32'd0);
            next_cycle();
            #1;
            chk("R4", "held level busy", 32'(busy), 32'd0);
            chk("R4", "held level we", 32'(mem_we), 32'd0);
        end else begin
            run_entry(inject, 1'b0);
        end
        next_cycle();
        nmi_req = 1'b0;
        #1;
        chk("R8", "busy after", 32'(busy), 32'd0);
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; nmi_req = 1'b0; nmi_gate = 1'b0; pc_in = 16'h0;
        core_push = 1'b0; core_pop = 1'b0; core_wdata = 8'h0;
        stat_we = 1'b0; stat_wdata = 8'h0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "sp reset", 32'(sp_out), 32'hFF);
        chk("R1", "status reset", 32'(status_out), 32'h20);
        chk("R1", "busy reset", 32'(busy), 32'd1);
        rst_n = 1'b1;
        #1;
        chk("R1", "first addr", 32'(mem_addr), 32'h0000FFFC);
        chk("R1", "first we", 32'(mem_we), 32'd0);
        next_cycle();
        #1;
        chk("R1", "second addr", 32'(mem_addr), 32'h0000FFFD);
        chk("R1", "pc_load", 32'(pc_load), 32'd1);
        chk("R1", "pc_vec", 32'(pc_vec), 32'({mem_fn(16'hFFFD), mem_fn(16'hFFFC)}));
        next_cycle();
        #1;
        chk("R1", "busy released", 32'(busy), 32'd0);
        chk("R1", "no load", 32'(pc_load), 32'd0);
        sp_exp = 8'hFF;
        st_exp = 8'h20;

        // directed: edge overlapping core requests
        do_nmi(1'b1, 1'b1);
        do_nmi(1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom_range(0, 5));
            case (k)
                0: do_push(8'($urandom), 1'b0);
                1: do_pop();
                2: do_push(8'($urandom), 1'b1);
                3: do_stat(8'($urandom));
                default: do_nmi(1'($urandom), 1'($urandom));
            endcase
        end

        // directed: pointer wrap both ways (R2, R3)
        for (int j = 0; j < 256 && sp_exp != 8'hFF; j++) do_pop();
        do_pop();
        next_cycle();
        #1;
        chk("R3", "wrap to 00", 32'(sp_out), 32'h00);
        do_push(8'h77, 1'b0);
        next_cycle();
        #1;
        chk("R2", "wrap to FF", 32'(sp_out), 32'hFF);

        // directed: second edge during entry gives one more entry (R10)
        pc_in = 16'hBEEF;
        next_cycle();
        nmi_req = 1'b1; nmi_gate = 1'b1;
        #1;
        run_entry(1'b0, 1'b1);
        run_entry(1'b0, 1'b0);
        next_cycle();
        #1;
        chk("R10", "single retrigger", 32'(busy), 32'd0);
        next_cycle();
        nmi_req = 1'b0;
        #1;
        chk("R10", "still idle", 32'(busy), 32'd0);
        chk_regs("R10");

        finish_run();
    end

endmodule